// File: doc/BRIEF.md
# SPI Chip-Select Timing Controller

This block owns the chip-select lines of a serial peripheral controller. It sits beside the shifting engine and decides when a select line becomes active and when the engine may start a frame. It also decides how long the line stays active once the frame is over. Configuration arrives through a small word-wide register port:

- the index of the line to drive;
- the idle (inactive) level of every implemented line;
- the select mode;
- two guard words holding four 8-bit delays.

The engine raises `frame_req` when it has a frame to send. It shifts only while `frame_go` is high, and it answers with a one-cycle `frame_done` pulse. All guard delays are counted in SCK half-periods, taken from the `half_tick` pulse of the engine's clock divisor.

There are three modes. In automatic mode the line is asserted for each frame and released afterwards. In hold mode the line stays asserted across frames until software releases it. In off mode the lines remain at their idle levels while frames still run. The number of implemented lines is the parameter `NCS` (1 to 32). Only those bits of the idle-level register can be written, so software can learn the line count by writing all ones and reading the value back.

Top module: `spi_cs_timer`

## Requirements
- R1: After reset every line sits at idle level 1, `frame_go` is low, the index and mode read 0, guard word A (address 3) reads 0x0001_0001 and guard word B (address 4) reads 0x0000_0001.
- R2: Address 1 holds the idle levels, with bit n for line n. Only bits below `NCS` store data; a write of all ones reads back as 2^NCS-1, and a write of zero reads back as zero.
- R3: While selected, line `index` (address 0, bits [4:0]) is driven to the inverse of its idle bit. Every other line keeps its idle level, and an index of `NCS` or more selects no line.
- R4: Mode is held in address 2, bits [1:0]. Values 0 and 1 select automatic mode, in which a request asserts the line and `frame_go` rises only after lead-delay half-ticks, where the lead delay is guard A bits [7:0].
- R5: In automatic mode, after `frame_done` the line stays asserted for trail-delay half-ticks (guard A bits [23:16]) and is then released.
- R6: After a release, the line stays deselected for at least the deselect time, in half-ticks (guard B bits [7:0]), before it can be asserted again.
- R7: In hold mode (value 2) the line stays asserted between frames and while idle. Each later frame starts after gap half-ticks (guard B bits [23:16]) with no lead delay.
- R8: A held line is released when the mode is set to anything but hold, or when the index or idle-level register is written.
- R9: In off mode (value 3) all lines stay at their idle levels. A request is granted at once, and the gap delay separates frames.
- R10: A guard value of 0 adds no half-tick. The waiting state then lasts a single clock cycle.
- R11: Once `frame_go` rises it stays high until `frame_done` is sampled, and it falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address (read and write) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| half_tick | input | 1 | One-cycle pulse per SCK half-period from the divisor |
| frame_req | input | 1 | Engine has a frame pending |
| frame_done | input | 1 | One-cycle pulse when the engine finishes a frame |
| frame_go | output | 1 | Permission for the engine to shift the frame |
| cs_lines | output | NCS | Chip-select line levels |

## Verification
The embedded properties assume two things about the inputs. Configuration writes arrive only while no frame is in progress, and `frame_done` pulses only while `frame_go` is high. The off-mode and release properties depend on both. The bench keeps within these limits in three ways. It issues every register write before raising `frame_req`, or after the last frame has been acknowledged. It pulses `frame_done` only after it has seen the grant. It paces `half_tick` once every four clocks, so the number of half-ticks in a waiting window is exact and the bench can compute it directly from the programmed guard values.

// File: rtl/spi_cs_pkg.sv
// Shared constants and types for the chip-select timing controller.
// Assumes at most 32 select lines and 8-bit guard delays.
package spi_cs_pkg;

    localparam int CS_MAX = 32;
    localparam int IDX_W  = $clog2(CS_MAX);
    localparam int DLY_W  = 8;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_INDEX = 3'd0;
    localparam logic [ADDR_W-1:0] A_LEVEL = 3'd1;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd2;
    localparam logic [ADDR_W-1:0] A_GUARD = 3'd3;
    localparam logic [ADDR_W-1:0] A_SPACE = 3'd4;

    typedef enum logic [1:0] {
        CSM_AUTO     = 2'd0,
        CSM_AUTO_ALT = 2'd1,
        CSM_HOLD     = 2'd2,
        CSM_OFF      = 2'd3
    } cs_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_RUN,
        ST_TRAIL,
        ST_DESEL,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        logic [DLY_W-1:0] lead;
        logic [DLY_W-1:0] trail;
        logic [DLY_W-1:0] desel;
        logic [DLY_W-1:0] gap;
    } guard_t;

endpackage

// File: rtl/spi_cs_regs.sv
// Configuration registers: line index, idle levels, mode and two guard words.
// Only the NCS implemented idle bits store data. Any write to the index or
// idle-level register raises rel_evt for one cycle. Assumes 1 <= NCS <= 32.
module spi_cs_regs
    import spi_cs_pkg::*;
#(
    parameter int NCS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [NCS-1:0]    idle_lvl,
    output cs_mode_e          mode,
    output guard_t            guard,
    output logic              rel_evt
);

    logic [IDX_W-1:0] idx_q;
    logic [NCS-1:0]   idle_q;
    cs_mode_e         mode_q;
    guard_t           guard_q;
    logic             unused_wbits;

    assign unused_wbits = ^{wdata[31:24], wdata[15:8]};

    // Register writes and reset defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q         <= '0;
            idle_q        <= '1;
            mode_q        <= CSM_AUTO;
            guard_q.lead  <= DLY_W'(1);
            guard_q.trail <= DLY_W'(1);
            guard_q.desel <= DLY_W'(1);
            guard_q.gap   <= '0;
        end else if (wr) begin
            case (addr)
                A_INDEX: idx_q  <= wdata[IDX_W-1:0];
                A_LEVEL: idle_q <= wdata[NCS-1:0];
                A_MODE:  mode_q <= cs_mode_e'(wdata[1:0]);
                A_GUARD: begin
                    guard_q.lead  <= wdata[7:0];
                    guard_q.trail <= wdata[23:16];
                end
                A_SPACE: begin
                    guard_q.desel <= wdata[7:0];
                    guard_q.gap   <= wdata[23:16];
                end
                default: ;
            endcase
        end
    end

    // Read-back multiplexer
    always_comb begin
        case (addr)
            A_INDEX: rdata = DATA_W'(idx_q);
            A_LEVEL: rdata = DATA_W'(idle_q);
            A_MODE:  rdata = DATA_W'(mode_q);
            A_GUARD: rdata = {8'd0, guard_q.trail, 8'd0, guard_q.lead};
            A_SPACE: rdata = {8'd0, guard_q.gap, 8'd0, guard_q.desel};
            default: rdata = '0;
        endcase
    end

    assign rel_evt  = wr && ((addr == A_INDEX) || (addr == A_LEVEL));
    assign sel_idx  = idx_q;
    assign idle_lvl = idle_q;
    assign mode     = mode_q;
    assign guard    = guard_q;

    a_r2_level_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_LEVEL) |=> (idle_q == $past(wdata[NCS-1:0])));

endmodule

// File: rtl/spi_cs_delay_cnt.sv
// Guard-delay down-counter. A load takes priority over a tick. Each half_tick
// decrements a non-zero count, and zero reports an expired delay.
module spi_cs_delay_cnt
    import spi_cs_pkg::*;
#(
    parameter int W = DLY_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    // Load or count down on half-period ticks
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && (cnt_q != '0))
            cnt_q <= cnt_q - W'(1);
    end

    assign zero = (cnt_q == '0);

    a_r10_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick && !zero) |=> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/spi_cs_seq.sv
// Frame sequencer. It asserts the select, waits out the lead delay, grants the
// frame, then applies the trail and deselect delays (automatic mode) or the
// gap delay (hold and off modes). A held select is released in idle when the
// mode leaves hold or when a release event is pending. Assumes configuration
// is written only between frames and that done pulses only while granted.
module spi_cs_seq
    import spi_cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cs_mode_e         mode,
    input  guard_t           guard,
    input  logic             rel_evt,
    input  logic             frame_req,
    input  logic             frame_done,
    input  logic             cnt_zero,
    output logic             cnt_load,
    output logic [DLY_W-1:0] cnt_val,
    output logic             cs_on,
    output logic             frame_go
);

    seq_state_e st_q, st_n;
    logic       on_q, on_n;
    logic       pend_q;
    logic       is_hold, no_sel;

    assign is_hold = (mode == CSM_HOLD);
    assign no_sel  = (mode == CSM_OFF);

    // Next-state and counter-load decisions
    always_comb begin
        st_n     = st_q;
        on_n     = on_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        case (st_q)
            ST_IDLE: begin
                if (on_q && (!is_hold || pend_q)) begin
                    st_n     = ST_DESEL;
                    on_n     = 1'b0;
                    cnt_load = 1'b1;
                    cnt_val  = guard.desel;
                end else if (frame_req) begin
                    if (no_sel || (is_hold && on_q)) begin
                        st_n = ST_RUN;
                    end else begin
                        st_n     = ST_LEAD;
                        on_n     = 1'b1;
                        cnt_load = 1'b1;
                        cnt_val  = guard.lead;
                    end
                end
            end
            ST_LEAD: begin
                if (cnt_zero) st_n = ST_RUN;
            end
            ST_RUN: begin
                if (frame_done) begin
                    cnt_load = 1'b1;
                    if (is_hold || no_sel) begin
                        st_n    = ST_GAP;
                        cnt_val = guard.gap;
                    end else begin
                        st_n    = ST_TRAIL;
                        cnt_val = guard.trail;
                    end
                end
            end
            ST_TRAIL: begin
                if (cnt_zero) begin
                    st_n     = ST_DESEL;
                    on_n     = 1'b0;
                    cnt_load = 1'b1;
                    cnt_val  = guard.desel;
                end
            end
            ST_DESEL, ST_GAP: begin
                if (cnt_zero) st_n = ST_IDLE;
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State and select-flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
            on_q <= 1'b0;
        end else begin
            st_q <= st_n;
            on_q <= on_n;
        end
    end

    // Pending release: set by index/idle writes, cleared once idle resolves it
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (rel_evt)
            pend_q <= 1'b1;
        else if ((st_q == ST_IDLE) && (!on_q || (st_n == ST_DESEL)))
            pend_q <= 1'b0;
    end

    assign cs_on    = on_q;
    assign frame_go = (st_q == ST_RUN);

    a_r11_go_held: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_go && !frame_done) |=> frame_go);

    a_r6_release_enters_desel: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(on_q) |-> (st_q == ST_DESEL));

    a_r4_lead_expired: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_RUN) && ($past(st_q) == ST_LEAD)) |-> $past(cnt_zero));

    a_r9_off_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        (no_sel && (st_q != ST_IDLE)) |-> !on_q);

endmodule

// File: rtl/spi_cs_drive.sv
// Line driver. Each implemented line shows its idle level, inverted only when
// the select flag is set and the index names that line.
module spi_cs_drive
    import spi_cs_pkg::*;
#(
    parameter int NCS = 4
) (
    input  logic [NCS-1:0]   idle_lvl,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic             cs_on,
    output logic [NCS-1:0]   cs_lines
);

    for (genvar i = 0; i < NCS; i++) begin : g_line
        // Invert the idle level on the selected line only
        assign cs_lines[i] = idle_lvl[i] ^ (cs_on && (sel_idx == IDX_W'(i)));
    end

endmodule

// File: rtl/spi_cs_timer.sv
// Chip-select timing controller top. Ties the register file, the frame
// sequencer, the shared guard counter and the line driver together.
// Assumes half_tick is a single-cycle pulse from the SCK divisor.
module spi_cs_timer
    import spi_cs_pkg::*;
#(
    parameter int NCS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              half_tick,
    input  logic              frame_req,
    input  logic              frame_done,
    output logic              frame_go,
    output logic [NCS-1:0]    cs_lines
);

    logic [IDX_W-1:0] sel_idx;
    logic [NCS-1:0]   idle_lvl;
    cs_mode_e         mode;
    guard_t           guard;
    logic             rel_evt;
    logic             cnt_load, cnt_zero, cs_on;
    logic [DLY_W-1:0] cnt_val;

    spi_cs_regs #(.NCS(NCS)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .sel_idx  (sel_idx),
        .idle_lvl (idle_lvl),
        .mode     (mode),
        .guard    (guard),
        .rel_evt  (rel_evt)
    );

    spi_cs_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .guard      (guard),
        .rel_evt    (rel_evt),
        .frame_req  (frame_req),
        .frame_done (frame_done),
        .cnt_zero   (cnt_zero),
        .cnt_load   (cnt_load),
        .cnt_val    (cnt_val),
        .cs_on      (cs_on),
        .frame_go   (frame_go)
    );

    spi_cs_delay_cnt #(.W(DLY_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .tick     (half_tick),
        .zero     (cnt_zero)
    );

    spi_cs_drive #(.NCS(NCS)) drive_i (
        .idle_lvl (idle_lvl),
        .sel_idx  (sel_idx),
        .cs_on    (cs_on),
        .cs_lines (cs_lines)
    );

endmodule

// File: tb/spi_cs_timer_tb_top.sv
`timescale 1ns/1ps
module spi_cs_timer_tb_top;

    localparam int NCS = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_wr = 1'b0;
    logic [2:0]     cfg_addr = '0;
    logic [31:0]    cfg_wdata = '0;
    logic [31:0]    cfg_rdata;
    logic           half_tick = 1'b0;
    logic           frame_req = 1'b0;
    logic           frame_done = 1'b0;
    logic           frame_go;
    logic [NCS-1:0] cs_lines;

    int             n_chk = 0;
    int             n_bad = 0;
    int             tph = 0;
    logic [NCS-1:0] cur_idle = '1;

    always #2 clk = ~clk;

    spi_cs_timer #(.NCS(NCS)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .half_tick  (half_tick),
        .frame_req  (frame_req),
        .frame_done (frame_done),
        .frame_go   (frame_go),
        .cs_lines   (cs_lines)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Advance one clock; set the tick for the following edge (one in four)
    task automatic step();
        @(posedge clk);
        #1;
        tph       = (tph + 1) % 4;
        half_tick = (tph == 0);
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        cfg_wr    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        step();
        cfg_wr    = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    function automatic logic [NCS-1:0] act_pat(input logic [NCS-1:0] idle, input int idx);
        if (idx < NCS) return idle ^ (NCS'(1) << idx);
        return idle;
    endfunction

    // Measure a waiting window: kind 0 = asserted and no grant,
    // kind 1 = deselected, kind 2 = no grant
    task automatic win(input int kind, input bit chk_en, input logic [NCS-1:0] expcs,
                       output int cyc, output int tk, output int bad);
        bit cond;
        cyc = 0; tk = 0; bad = 0;
        forever begin
            case (kind)
                0:       cond = (cs_lines != cur_idle) && !frame_go;
                1:       cond = (cs_lines == cur_idle);
                default: cond = !frame_go;
            endcase
            if (!cond || cyc >= 400) break;
            if (chk_en && cs_lines != expcs) bad++;
            cyc++;
            tk += int'(half_tick);
            step();
        end
    endtask

    task automatic check_delay(input string tag, input int v, input int cyc,
                               input int tk, input int zero_cyc);
        if (v > 0) check(tk == v, tag, tk, v);
        else       check(cyc == zero_cyc, {"R10 zero delay ", tag}, cyc, zero_cyc);
    endtask

    // Engine model: keep the grant for a few cycles, then pulse done
    task automatic engine_frame(input bit last);
        check(frame_go == 1'b1, "R11 grant present", frame_go, 1);
        step();
        check(frame_go == 1'b1, "R11 grant held", frame_go, 1);
        step();
        check(frame_go == 1'b1, "R11 grant held", frame_go, 1);
        frame_done = 1'b1;
        frame_req  = !last;
        step();
        frame_done = 1'b0;
        check(frame_go == 1'b0, "R11 grant drops after done", frame_go, 0);
    endtask

    initial begin
        logic [31:0]    rd;
        int             cyc, tk, bad;
        int             lead_v[3]  = '{0, 1, 3};
        int             trail_v[2] = '{0, 2};
        int             desel_v[2] = '{1, 2};
        int             gap_v[3]   = '{0, 1, 3};
        logic [NCS-1:0] expa;

        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1: reset state
        check(cs_lines == '1, "R1 lines idle high", cs_lines, 15);
        check(frame_go == 1'b0, "R1 no grant", frame_go, 0);
        cfg_read(3'd0, rd); check(rd == 0, "R1 index", rd, 0);
        cfg_read(3'd2, rd); check(rd == 0, "R1 mode", rd, 0);
        cfg_read(3'd3, rd); check(rd == 32'h0001_0001, "R1 guard A", rd, 32'h0001_0001);
        cfg_read(3'd4, rd); check(rd == 32'h0000_0001, "R1 guard B", rd, 1);

        // R2: only implemented idle bits are writable
        cfg_write(3'd1, 32'hFFFF_FFFF);
        cfg_read(3'd1, rd); check(rd == 32'h0000_000F, "R2 all-ones probe", rd, 15);
        cfg_write(3'd1, 32'h0);
        cfg_read(3'd1, rd); check(rd == 0, "R2 zero write", rd, 0);

        // Automatic mode sweep: index, lead, trail and deselect values
        for (int idx = 0; idx < NCS; idx++)
            for (int li = 0; li < 3; li++)
                for (int ti = 0; ti < 2; ti++)
                    for (int di = 0; di < 2; di++) begin
                        cur_idle = NCS'((idx * 7 + lead_v[li] * 3 + trail_v[ti] * 5 + desel_v[di]) & 15);
                        cfg_write(3'd1, 32'(cur_idle));
                        cfg_write(3'd0, 32'(idx));
                        cfg_write(3'd2, (trail_v[ti] == 2) ? 32'd1 : 32'd0);
                        cfg_write(3'd3, {8'd0, 8'(trail_v[ti]), 8'd0, 8'(lead_v[li])});
                        cfg_write(3'd4, {8'd0, 8'd0, 8'd0, 8'(desel_v[di])});
                        expa = act_pat(cur_idle, idx);
                        frame_req = 1'b1;
                        step();
                        check(cs_lines == expa, "R3 selected line inverted", cs_lines, expa);
                        win(2, 1'b1, expa, cyc, tk, bad);
                        check(bad == 0, "R3 pattern during lead", bad, 0);
                        check_delay("R4 lead", lead_v[li], cyc, tk, 1);
                        engine_frame(1'b0);
                        win(0, 1'b1, expa, cyc, tk, bad);
                        check_delay("R5 trail", trail_v[ti], cyc, tk, 1);
                        check(cs_lines == cur_idle, "R5 released", cs_lines, cur_idle);
                        win(1, 1'b0, expa, cyc, tk, bad);
                        check_delay("R6 deselect", desel_v[di], cyc, tk, 2);
                        check(cs_lines == expa, "R6 reasserted", cs_lines, expa);
                        win(2, 1'b1, expa, cyc, tk, bad);
                        check_delay("R4 lead second", lead_v[li], cyc, tk, 1);
                        engine_frame(1'b1);
                        win(0, 1'b1, expa, cyc, tk, bad);
                        check_delay("R5 trail second", trail_v[ti], cyc, tk, 1);
                        bad = 0;
                        for (int k = 0; k < 12; k++) begin
                            if (cs_lines != cur_idle || frame_go) bad++;
                            step();
                        end
                        check(bad == 0, "R4 auto release stays idle", bad, 0);
                    end

        // R3: out-of-range index selects nothing
        for (int oi = 0; oi < 2; oi++) begin
            cur_idle = 4'b1010;
            cfg_write(3'd1, 32'(cur_idle));
            cfg_write(3'd0, (oi == 0) ? 32'd4 : 32'd7);
            cfg_write(3'd2, 32'd0);
            cfg_write(3'd3, 32'h0001_0001);
            frame_req = 1'b1;
            step();
            win(2, 1'b1, cur_idle, cyc, tk, bad);
            check(bad == 0, "R3 out-of-range index no line", bad, 0);
            engine_frame(1'b1);
            bad = 0;
            for (int k = 0; k < 16; k++) begin
                if (cs_lines != cur_idle) bad++;
                step();
            end
            check(bad == 0, "R3 out-of-range index after frame", bad, 0);
        end

        // Hold mode: gap sweep and the three release triggers
        for (int gi = 0; gi < 3; gi++)
            for (int rv = 0; rv < 3; rv++) begin
                cur_idle = 4'b0110 ^ NCS'(rv);
                cfg_write(3'd1, 32'(cur_idle));
                cfg_write(3'd0, 32'(rv + 1));
                cfg_write(3'd2, 32'd2);
                cfg_write(3'd3, 32'h0001_0002);
                cfg_write(3'd4, {8'd0, 8'(gap_v[gi]), 8'd0, 8'd1});
                repeat (8) step();
                expa = act_pat(cur_idle, rv + 1);
                frame_req = 1'b1;
                step();
                win(2, 1'b1, expa, cyc, tk, bad);
                check_delay("R4 hold first lead", 2, cyc, tk, 1);
                for (int f = 0; f < 2; f++) begin
                    engine_frame(1'b0);
                    win(2, 1'b1, expa, cyc, tk, bad);
                    check(bad == 0, "R7 held between frames", bad, 0);
                    check_delay("R7 gap no lead", gap_v[gi], cyc, tk, 2);
                end
                engine_frame(1'b1);
                bad = 0;
                for (int k = 0; k < 24; k++) begin
                    if (cs_lines != expa) bad++;
                    step();
                end
                check(bad == 0, "R7 held while idle", bad, 0);
                case (rv)
                    0:       cfg_write(3'd2, 32'd0);
                    1:       cfg_write(3'd0, 32'(rv + 1));
                    default: cfg_write(3'd1, 32'(cur_idle));
                endcase
                step();
                check(cs_lines == cur_idle, "R8 hold release", cs_lines, cur_idle);
                repeat (8) step();
            end

        // R9: off mode keeps lines idle, grants at once, applies gap
        cur_idle = 4'b1001;
        cfg_write(3'd1, 32'(cur_idle));
        cfg_write(3'd0, 32'd1);
        cfg_write(3'd2, 32'd3);
        cfg_write(3'd4, 32'h0002_0001);
        repeat (8) step();
        frame_req = 1'b1;
        step();
        check(frame_go == 1'b1, "R9 immediate grant", frame_go, 1);
        check(cs_lines == cur_idle, "R9 lines idle", cs_lines, cur_idle);
        engine_frame(1'b0);
        win(2, 1'b1, cur_idle, cyc, tk, bad);
        check(bad == 0, "R9 lines idle in gap", bad, 0);
        check_delay("R9 gap", 2, cyc, tk, 2);
        engine_frame(1'b1);
        step();
        check(cs_lines == cur_idle, "R9 lines idle after", cs_lines, cur_idle);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: counts as a failed check
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R11 act=%0d exp=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule